// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block turns the 32 pins of one GPIO port into a single port interrupt. Four per-pin configuration registers choose, bit by bit, whether the pin may raise the interrupt, which level or edge direction counts as active, whether detection is by level or by edge, and whether the pin also drives the interrupt through a path with no clock. A pending-flag register records the detected events. Software clears a flag by writing a one to its bit.

The registers sit on a simple write/read bus. The address holds a register group in bits [11:8], the port index in bits [7:4], and an access alias in bits [3:2]. Bits [1:0] must be zero. The block only responds when the port field equals its `PORT_IDX` parameter, so many instances can share one bus. Clocked detection works from the already synchronized pin values. The combinational path uses the raw pin values directly.

Top module: `pin_event_irq`

## Requirements
- R1: A write takes effect only when wr_addr[7:4] equals PORT_IDX and wr_addr[1:0] is 0. A write with any other port field, or to an unmapped group, changes no register.
- R2: Register groups are selected by address bits [11:8]: 0x4 is enable, 0x5 is polarity, 0x6 is type and 0x7 is async. Address bits [3:2] choose the alias: 0 writes the value, 1 ORs the data in, 2 clears the bits set in the data, and 3 inverts the bits set in the data. A read from any alias of a group returns that register.
- R3: The pending-flag register is group 0x3, alias 0. Writing 1 to a bit clears that flag. Writing 0 leaves the flag unchanged.
- R4: A polarity bit of 0 makes high level or rising edge active. A polarity bit of 1 makes low level or falling edge active.
- R5: With a type bit of 0 (level), the flag is set on every clock edge on which the synchronized pin is at its active level.
- R6: With a type bit of 1 (edge), the flag is set only on a clock edge where the current synchronized sample is active and the previous one was not. A held level does not set it again after a clear.
- R7: If an event and a write-one-to-clear hit the same flag bit on the same edge, the flag stays set.
- R8: irq is the OR over all bits of flag AND enable. A pin whose enable bit is 0 cannot raise irq, although its flag still records events.
- R9: For a pin whose async bit is 1 and whose enable bit is 1, an active raw input level drives irq high with no clock edge. For a pin whose async bit is 0, the raw input has no effect.
- R10: Synchronous reset clears all configuration and flag registers. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write address (group, port, alias) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| pin_sync | input | 32 | Synchronized pin levels |
| pin_raw | input | 32 | Raw pin levels for the combinational path |
| irq | output | 1 | Port interrupt |

## Verification
Every state element is visible within one read or one clock edge. A wrong flag or configuration bit shows up in rd_data on the same cycle it is read back. It also shows up on irq in the cycle after the event edge, provided that pin is enabled. A faulty edge-history register is harder to see: it only shows as a missing or extra flag on the edge after a pin transition. For that reason the tests hold levels across a clear and reverse pin direction under both polarities. The combinational path is checked between clock edges, so a registered implementation of it would show up as irq arriving one cycle late.

// File: rtl/pei_pkg.sv
package pei_pkg;

    localparam int PIN_W  = 32;
    localparam int ADDR_W = 12;

    localparam logic [3:0] GRP_FLAG  = 4'h3;
    localparam logic [3:0] GRP_EN    = 4'h4;
    localparam logic [3:0] GRP_POL   = 4'h5;
    localparam logic [3:0] GRP_TYPE  = 4'h6;
    localparam logic [3:0] GRP_ASYNC = 4'h7;

    typedef logic [PIN_W-1:0] pin_vec_t;

    typedef enum logic [1:0] {
        AL_VALUE  = 2'd0,
        AL_SET    = 2'd1,
        AL_CLEAR  = 2'd2,
        AL_TOGGLE = 2'd3
    } alias_e;

    typedef struct packed {
        logic       hit;
        logic [3:0] grp;
        alias_e     al;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a, input logic [3:0] port);
        dec_t d;
        d.hit = (a[7:4] == port) && (a[1:0] == 2'b00);
        d.grp = a[11:8];
        d.al  = alias_e'(a[3:2]);
        return d;
    endfunction

    function automatic pin_vec_t apply_alias(input alias_e al, input pin_vec_t cur, input pin_vec_t wd);
        case (al)
            AL_VALUE:  return wd;
            AL_SET:    return cur | wd;
            AL_CLEAR:  return cur & ~wd;
            default:   return cur ^ wd;
        endcase
    endfunction

endpackage

// File: rtl/pei_cfg_reg.sv
module pei_cfg_reg
    import pei_pkg::*;
#(
    parameter logic [3:0] GROUP = GRP_EN
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_hit,
    input  dec_t     dec,
    input  pin_vec_t wd,
    output pin_vec_t q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_hit && dec.grp == GROUP)
            q <= apply_alias(dec.al, q, wd);
    end

endmodule

// File: rtl/pei_detect.sv
module pei_detect
    import pei_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t pin_sync,
    input  pin_vec_t pol,
    input  pin_vec_t typ,
    output pin_vec_t ev
);

    pin_vec_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= pin_sync;
    end

    // Per pin: polarity folds into an "active" view of current and previous samples
    for (genvar i = 0; i < PIN_W; i++) begin : g_bit
        logic act_now;
        logic act_prev;
        assign act_now  = pin_sync[i] ^ pol[i];
        assign act_prev = prev_q[i] ^ pol[i];
        assign ev[i]    = typ[i] ? (act_now & ~act_prev) : act_now;
    end

endmodule

// File: rtl/pei_irq_merge.sv
module pei_irq_merge
    import pei_pkg::*;
(
    input  pin_vec_t flag,
    input  pin_vec_t en,
    input  pin_vec_t async_sel,
    input  pin_vec_t pol,
    input  pin_vec_t pin_raw,
    output logic     irq
);

    pin_vec_t latched_src;
    pin_vec_t bypass_src;

    assign latched_src = flag & en;
    assign bypass_src  = async_sel & en & (pin_raw ^ pol);
    assign irq         = (|latched_src) | (|bypass_src);

endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
    import pei_pkg::*;
#(
    parameter int PORT_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PIN_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PIN_W-1:0]  rd_data,
    input  logic [PIN_W-1:0]  pin_sync,
    input  logic [PIN_W-1:0]  pin_raw,
    output logic              irq
);

    localparam logic [3:0] PORT_TAG = 4'(PORT_IDX);
    localparam int         NCFG     = 4;

    dec_t     wdec;
    dec_t     rdec;
    logic     wr_port_hit;
    pin_vec_t cfg_q [NCFG];
    pin_vec_t en_q, pol_q, typ_q, async_q;
    pin_vec_t ev;
    pin_vec_t flag_q;
    pin_vec_t w1c;

    assign wdec        = decode(wr_addr, PORT_TAG);
    assign rdec        = decode(rd_addr, PORT_TAG);
    assign wr_port_hit = wr_en && wdec.hit;

    // Configuration groups are consecutive: enable, polarity, type, async
    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        pei_cfg_reg #(.GROUP(GRP_EN + 4'(g))) u_cfg (
            .clk    (clk),
            .rst    (rst),
            .wr_hit (wr_port_hit),
            .dec    (wdec),
            .wd     (wr_data),
            .q      (cfg_q[g])
        );
    end

    assign en_q    = cfg_q[0];
    assign pol_q   = cfg_q[1];
    assign typ_q   = cfg_q[2];
    assign async_q = cfg_q[3];

    pei_detect u_det (
        .clk      (clk),
        .rst      (rst),
        .pin_sync (pin_sync),
        .pol      (pol_q),
        .typ      (typ_q),
        .ev       (ev)
    );

    assign w1c = (wr_port_hit && wdec.grp == GRP_FLAG && wdec.al == AL_VALUE) ? wr_data : '0;

    // A fresh event is ORed after the clear so it wins a same-edge collision
    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (flag_q & ~w1c) | ev;
    end

    pei_irq_merge u_mrg (
        .flag      (flag_q),
        .en        (en_q),
        .async_sel (async_q),
        .pol       (pol_q),
        .pin_raw   (pin_raw),
        .irq       (irq)
    );

    always_comb begin
        rd_data = '0;
        if (rdec.hit) begin
            case (rdec.grp)
                GRP_FLAG:  rd_data = (rdec.al == AL_VALUE) ? flag_q : '0;
                GRP_EN:    rd_data = en_q;
                GRP_POL:   rd_data = pol_q;
                GRP_TYPE:  rd_data = typ_q;
                GRP_ASYNC: rd_data = async_q;
                default:   rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/pei_checker.sv
module pei_checker
    import pei_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     wr_en,
    input logic     wr_port_hit,
    input pin_vec_t pin_sync,
    input pin_vec_t en_q,
    input pin_vec_t pol_q,
    input pin_vec_t typ_q,
    input pin_vec_t async_q,
    input pin_vec_t flag_q,
    input pin_vec_t ev,
    input logic     irq
);

    assert_foreign_write_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_port_hit) |=> ($stable(en_q) && $stable(pol_q) && $stable(typ_q) && $stable(async_q)));

    assert_level_raises_R5: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && |(en_q & ~typ_q & (pin_sync ^ pol_q))) |=> irq);

    assert_no_spurious_flag_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(ev)) == '0));

    assert_event_wins_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & $past(ev)) == $past(ev)));

    assert_mask_all_R8: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq);

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (en_q == '0 && flag_q == '0 && async_q == '0 && !irq));

endmodule

bind pin_event_irq pei_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_port_hit (wr_port_hit),
    .pin_sync    (pin_sync),
    .en_q        (en_q),
    .pol_q       (pol_q),
    .typ_q       (typ_q),
    .async_q     (async_q),
    .flag_q      (flag_q),
    .ev          (ev),
    .irq         (irq)
);

// File: tb/sim_pin_event_irq.sv
module sim_pin_event_irq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] pin_sync = '0;
    logic [31:0] pin_raw = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pin_event_irq #(.PORT_IDX(2)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_sync(pin_sync), .pin_raw(pin_raw), .irq(irq)
    );

    typedef struct packed {
        logic [11:0] wa;
        logic [31:0] wd;
        logic [11:0] ra;
        logic [31:0] exp;
    } vec_t;

    // Port 2: flag 0x320, enable 0x42x, polarity 0x52x, type 0x62x, async 0x72x
    localparam vec_t VEC [13] = '{
        '{12'h420, 32'h0000_00F0, 12'h420, 32'h0000_00F0},
        '{12'h424, 32'h0000_000F, 12'h420, 32'h0000_00FF},
        '{12'h428, 32'h0000_003C, 12'h42C, 32'h0000_00C3},
        '{12'h42C, 32'hFF00_0001, 12'h420, 32'hFF00_00C2},
        '{12'h400, 32'hFFFF_FFFF, 12'h420, 32'hFF00_00C2},
        '{12'h520, 32'hA5A5_A5A5, 12'h520, 32'hA5A5_A5A5},
        '{12'h52C, 32'hFFFF_FFFF, 12'h524, 32'h5A5A_5A5A},
        '{12'h620, 32'h1234_5678, 12'h620, 32'h1234_5678},
        '{12'h628, 32'h0000_0078, 12'h620, 32'h1234_5600},
        '{12'h724, 32'h8000_0001, 12'h720, 32'h8000_0001},
        '{12'h730, 32'h0000_FFFF, 12'h720, 32'h8000_0001},
        '{12'h72C, 32'h0000_0003, 12'h720, 32'h8000_0002},
        '{12'h820, 32'h0000_0001, 12'h820, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        rd(12'h420, v); chk("R10 enable reset", v, 32'h0);
        rd(12'h520, v); chk("R10 polarity reset", v, 32'h0);
        rd(12'h620, v); chk("R10 type reset", v, 32'h0);
        rd(12'h720, v); chk("R10 async reset", v, 32'h0);
        rd(12'h320, v); chk("R10 flag reset", v, 32'h0);
        chk("R10 irq reset", {31'b0, irq}, 32'h0);

        // R1 R2 R10: alias table walk
        foreach (VEC[k]) begin
            wr(VEC[k].wa, VEC[k].wd);
            rd(VEC[k].ra, v);
            chk($sformatf("R1/R2 vector %0d", k), v, VEC[k].exp);
        end

        // restore a clean configuration
        wr(12'h420, 32'h0); wr(12'h520, 32'h0); wr(12'h620, 32'h0); wr(12'h720, 32'h0);
        wr(12'h320, 32'hFFFF_FFFF);
        rd(12'h320, v); chk("R3 clear all flags", v, 32'h0);

        // R5 R7 R3: level high on pin 0
        wr(12'h424, 32'h1);
        pin_sync[0] = 1'b1;
        @(negedge clk);
        rd(12'h320, v); chk("R5 level sets flag", v, 32'h1);
        chk("R5 irq from level", {31'b0, irq}, 32'h1);
        wr(12'h320, 32'h1);
        rd(12'h320, v); chk("R7 event beats clear", v, 32'h1);
        pin_sync[0] = 1'b0;
        @(negedge clk);
        wr(12'h320, 32'h0);
        rd(12'h320, v); chk("R3 write zero no effect", v, 32'h1);
        wr(12'h320, 32'h1);
        rd(12'h320, v); chk("R3 write one clears", v, 32'h0);
        chk("R3 irq drops", {31'b0, irq}, 32'h0);

        // R6 R4: rising edge on pin 1
        wr(12'h624, 32'h2); wr(12'h424, 32'h2);
        pin_sync[1] = 1'b1;
        @(negedge clk);
        rd(12'h320, v); chk("R6 rising edge sets flag", v, 32'h2);
        wr(12'h320, 32'h2);
        rd(12'h320, v); chk("R6 held level no re-set", v, 32'h0);
        chk("R6 irq after clear", {31'b0, irq}, 32'h0);
        pin_sync[1] = 1'b0;
        @(negedge clk);
        rd(12'h320, v); chk("R4 falling ignored at pol 0", v, 32'h0);

        // R4: falling edge on pin 2
        wr(12'h624, 32'h4); wr(12'h524, 32'h4); wr(12'h424, 32'h4);
        wr(12'h320, 32'h4);
        pin_sync[2] = 1'b1;
        @(negedge clk);
        rd(12'h320, v); chk("R4 rising ignored at pol 1", v, 32'h0);
        pin_sync[2] = 1'b0;
        @(negedge clk);
        rd(12'h320, v); chk("R4 falling edge sets flag", v, 32'h4);
        chk("R4 irq on falling", {31'b0, irq}, 32'h1);
        wr(12'h320, 32'h4);

        // R8: masking on pin 5
        pin_sync[5] = 1'b1;
        @(negedge clk);
        rd(12'h320, v); chk("R8 flag records while masked", v, 32'h20);
        chk("R8 masked irq low", {31'b0, irq}, 32'h0);
        wr(12'h424, 32'h20);
        chk("R8 enabled irq high", {31'b0, irq}, 32'h1);
        wr(12'h428, 32'h20);
        chk("R8 disabled irq low", {31'b0, irq}, 32'h0);
        pin_sync[5] = 1'b0;
        @(negedge clk);
        wr(12'h320, 32'h20);

        // R9: combinational path on pin 3, none on pin 4
        wr(12'h724, 32'h8); wr(12'h424, 32'h18);
        pin_raw[3] = 1'b1;
        #1;
        chk("R9 async irq without clock", {31'b0, irq}, 32'h1);
        pin_raw[3] = 1'b0;
        #1;
        chk("R9 async irq follows raw", {31'b0, irq}, 32'h0);
        @(negedge clk);
        pin_raw[4] = 1'b1;
        #1;
        chk("R9 clocked pin ignores raw", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R9 clocked pin ignores raw after edge", {31'b0, irq}, 32'h0);
        rd(12'h320, v); chk("R9 no flag from raw", v, 32'h0);
        pin_raw[4] = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule